// File: doc/BRIEF.md
# Word-Access GPIO Register Slave

This block puts a small general-purpose I/O port behind a 32-bit synchronous processor bus. The bus side supplies an active-low chip select, two word-address bits (address bits 3 and 2), an access size code, a write strobe and 32 bits of write data. The block holds three registers: an output latch that drives the port's output pins, a direction register, and a pin register that samples the input pins. One of the four word slots is empty.

Register writes commit on the falling edge of the bus clock. Read data is placed on the bus only during the high phase of the clock, and only the low byte is driven. A per-bit enable vector tells the surrounding bus logic which bits are driven. The upper bits are never driven. An error flag reports any access that is not a 32-bit word access, and any access that goes against a register's direction. While the flag is up, no register changes, but a readable register still presents its data.

The upper address bits are decoded outside the block into the chip select. Because only two address bits reach the block, the four word slots repeat across the whole window covered by the chip select.

Top module: `gpio_bus_port`

## Requirements
- R1: While `rst` is high at a falling clock edge, the output latch and the direction register both clear to zero, so every pin starts as an input.
- R2: A legal write (chip select low, size 2'b10, write high) takes effect at the falling clock edge. Slot 2'b00 loads `wdata[7:0]` into the output latch, which drives `gpio_out`. Slot 2'b01 loads it into the direction register, which drives `gpio_dir` (1 means output).
- R3: A read of slot 2'b01 returns the direction register on `rdata[7:0]`.
- R4: A read of slot 2'b10 returns the `gpio_in` value that was captured at the most recent falling clock edge.
- R5: Read data is driven only while `clk` is high, `cs_n` is low, `wr` is low and the slot is readable. While driving, `rdata_oe` is all ones on bits [7:0]. At all other times `rdata_oe` is zero and `rdata` is zero. `rdata_oe[31:8]` is always zero.
- R6: `err` is high for any access with size 2'b00 (byte), 2'b01 (halfword) or 2'b11 (undefined). Only 2'b10 (word) is legal.
- R7: `err` is high for a read of slot 2'b00 (write-only) or slot 2'b11 (unused). It is also high for a write to slot 2'b10 (read-only) or slot 2'b11.
- R8: No register changes at a falling edge while `err` is high.
- R9: A read of a readable slot drives its data even when `err` is high because of the size.
- R10: With `cs_n` high, `err` is low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; writes at the falling edge, reads driven in the high phase |
| rst | input | 1 | Synchronous active-high reset, sampled at the falling edge |
| cs_n | input | 1 | Active-low chip select for the window |
| addr | input | 2 | Word address bits [3:2] |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 undefined |
| wr | input | 1 | 1 write, 0 read |
| wdata | input | 32 | Write data; only [7:0] is used |
| rdata | output | 32 | Read data; only [7:0] is ever non-zero |
| rdata_oe | output | 32 | Per-bit drive enable for `rdata` |
| err | output | 1 | Illegal access flag, combinational |
| gpio_out | output | 8 | Output latch value toward the pins |
| gpio_dir | output | 8 | Direction per pin, 1 = output |
| gpio_in | input | 8 | Input pin levels |

## Verification
The bench builds the block with its defaults: a 32-bit bus and an 8-bit port. With these values every combination of slot, size and direction is a small, finite space. Random traffic reaches all of these combinations many times over, and it carries full 8-bit data patterns through the output, direction and pin paths. The 24 upper bus bits are also wide enough to show that stray write data above the low byte never reaches a register and that those lanes are never enabled.

// File: rtl/gpio_bus_pkg.sv
package gpio_bus_pkg;

    typedef enum logic [1:0] {
        SLOT_OUT  = 2'b00,
        SLOT_DIR  = 2'b01,
        SLOT_PIN  = 2'b10,
        SLOT_NONE = 2'b11
    } slot_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    typedef struct packed {
        logic  err;
        logic  wr_en;
        logic  rd_en;
        slot_e slot;
    } access_s;

    function automatic logic slot_readable(slot_e s);
        return (s == SLOT_DIR) || (s == SLOT_PIN);
    endfunction

    function automatic logic slot_writable(slot_e s);
        return (s == SLOT_OUT) || (s == SLOT_DIR);
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_bus_pkg::*;
(
    input  logic        cs_n,
    input  logic [1:0]  addr,
    input  logic [1:0]  size,
    input  logic        wr,
    output access_s     acc
);
    slot_e slot;
    logic  sel;
    logic  size_bad;
    logic  dir_bad;

    always_comb begin
        slot     = slot_e'(addr);
        sel      = ~cs_n;
        size_bad = (size_e'(size) != SZ_WORD);
        dir_bad  = wr ? ~slot_writable(slot) : ~slot_readable(slot);

        acc.slot  = slot;
        acc.err   = sel & (size_bad | dir_bad);
        acc.wr_en = sel & wr & ~(size_bad | dir_bad);
        acc.rd_en = sel & ~wr & slot_readable(slot);
    end
endmodule

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
    import gpio_bus_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  access_s           acc,
    input  logic [PORT_W-1:0] wbyte,
    input  logic [PORT_W-1:0] pins,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] pin_q
);
    always_ff @(negedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (acc.wr_en) begin
            if (acc.slot == SLOT_OUT) out_q <= wbyte;
            if (acc.slot == SLOT_DIR) dir_q <= wbyte;
        end
    end

    always_ff @(negedge clk) begin
        pin_q <= pins;
    end
endmodule

// File: rtl/gpio_bus_rdmux.sv
module gpio_bus_rdmux
    import gpio_bus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  access_s           acc,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] pin_q,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] rdata_oe
);
    localparam int PAD_W = DATA_W - PORT_W;

    logic              drive;
    logic [PORT_W-1:0] sel_byte;

    always_comb begin
        drive    = clk & acc.rd_en;
        sel_byte = (acc.slot == SLOT_PIN) ? pin_q : dir_q;
        rdata    = '0;
        rdata_oe = '0;
        if (drive) begin
            rdata    = {{PAD_W{1'b0}}, sel_byte};
            rdata_oe = {{PAD_W{1'b0}}, {PORT_W{1'b1}}};
        end
    end
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
    import gpio_bus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [1:0]        addr,
    input  logic [1:0]        size,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] rdata_oe,
    output logic              err,
    output logic [PORT_W-1:0] gpio_out,
    output logic [PORT_W-1:0] gpio_dir,
    input  logic [PORT_W-1:0] gpio_in
);
    access_s           acc;
    logic [PORT_W-1:0] pin_q;

    gpio_bus_decode u_dec (
        .cs_n (cs_n),
        .addr (addr),
        .size (size),
        .wr   (wr),
        .acc  (acc)
    );

    gpio_bus_regs #(.PORT_W(PORT_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .wbyte (wdata[PORT_W-1:0]),
        .pins  (gpio_in),
        .out_q (gpio_out),
        .dir_q (gpio_dir),
        .pin_q (pin_q)
    );

    gpio_bus_rdmux #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_rd (
        .clk      (clk),
        .acc      (acc),
        .dir_q    (gpio_dir),
        .pin_q    (pin_q),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    assign err = acc.err;
endmodule

// File: rtl/gpio_bus_port_chk.sv
module gpio_bus_port_chk #(
    parameter int DATA_W = 32,
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic [1:0]        addr,
    input logic [1:0]        size,
    input logic              wr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata_oe,
    input logic              err,
    input logic [PORT_W-1:0] gpio_out,
    input logic [PORT_W-1:0] gpio_dir
);
    // R10: no error without chip select
    a_r10_err_needs_cs: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !err);

    // R6: non-word sizes are flagged
    a_r6_size_err: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && size != 2'b10) |-> err);

    // R7: read of the write-only slot is flagged and not driven
    a_r7_read_out_slot: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr && addr == 2'b00) |-> err);

    // R8: a flagged access leaves both registers unchanged at the falling edge
    a_r8_err_blocks_write: assert property (@(negedge clk) disable iff (rst)
        (!cs_n && wr && err) |=> ($stable(gpio_out) && $stable(gpio_dir)));

    // R2: legal direction write lands at the falling edge
    a_r2_dir_write: assert property (@(negedge clk) disable iff (rst)
        (!cs_n && wr && !err && addr == 2'b01) |=> (gpio_dir == $past(wdata[PORT_W-1:0])));

    // R5: no drive in the low phase or without chip select, never above the low byte
    always_comb begin
        if (!clk || cs_n) begin
            a_r5_no_drive_idle: assert (rdata_oe == '0);
        end
        a_r5_upper_never: assert (rdata_oe[DATA_W-1:PORT_W] == '0);
    end
endmodule

bind gpio_bus_port gpio_bus_port_chk #(.DATA_W(DATA_W), .PORT_W(PORT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .addr     (addr),
    .size     (size),
    .wr       (wr),
    .wdata    (wdata),
    .rdata_oe (rdata_oe),
    .err      (err),
    .gpio_out (gpio_out),
    .gpio_dir (gpio_dir)
);

// File: tb/gpio_bus_port_tb_top.sv
module gpio_bus_port_tb_top;
    localparam int DW = 32;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic [1:0]    addr = '0;
    logic [1:0]    size = 2'b10;
    logic          wr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [DW-1:0] rdata_oe;
    logic          err;
    logic [PW-1:0] gpio_out;
    logic [PW-1:0] gpio_dir;
    logic [PW-1:0] gpio_in = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic [PW-1:0] m_out = '0;
    logic [PW-1:0] m_dir = '0;
    logic [PW-1:0] m_pin = '0;

    always #10 clk = ~clk;

    gpio_bus_port #(.DATA_W(DW), .PORT_W(PW)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .size(size), .wr(wr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .err(err),
        .gpio_out(gpio_out), .gpio_dir(gpio_dir), .gpio_in(gpio_in)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic f_err(logic c_n, logic [1:0] a, logic [1:0] s, logic w);
        logic bad_dir;
        if (c_n) return 1'b0;
        bad_dir = w ? (a == 2'b10 || a == 2'b11) : (a == 2'b00 || a == 2'b11);
        return (s != 2'b10) || bad_dir;
    endfunction

    function automatic logic f_read(logic c_n, logic [1:0] a, logic w);
        return !c_n && !w && (a == 2'b01 || a == 2'b10);
    endfunction

    task automatic access(input logic c_n, input logic [1:0] a, input logic [1:0] s,
                          input logic w, input logic [DW-1:0] d, input logic [PW-1:0] pins);
        logic          e;
        logic          rd;
        logic [PW-1:0] val;
        @(posedge clk);
        #1;
        cs_n = c_n; addr = a; size = s; wr = w; wdata = d; gpio_in = pins;
        #4;
        e  = f_err(c_n, a, s, w);
        rd = f_read(c_n, a, w);
        val = (a == 2'b10) ? m_pin : m_dir;
        check(c_n ? "R10 err" : (s != 2'b10 ? "R6 err" : "R7 err"), {31'b0, err}, {31'b0, e});
        if (rd) begin
            check(e ? "R9 rdata" : (a == 2'b10 ? "R4 rdata" : "R3 rdata"), rdata, {24'b0, val});
            check("R5 oe high", rdata_oe, 32'h0000_00FF);
        end else begin
            check("R5 oe off", rdata_oe, '0);
            check("R5 rdata off", rdata, '0);
        end
        @(negedge clk);
        if (!c_n && w && !e) begin
            if (a == 2'b00) m_out = d[PW-1:0];
            if (a == 2'b01) m_dir = d[PW-1:0];
        end
        m_pin = pins;
        #1;
        check("R5 low phase oe", rdata_oe, '0);
        check(e ? "R8 out" : (c_n ? "R10 out" : "R2 out"), {24'b0, gpio_out}, {24'b0, m_out});
        check(e ? "R8 dir" : (c_n ? "R10 dir" : "R2 dir"), {24'b0, gpio_dir}, {24'b0, m_dir});
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 out reset", {24'b0, gpio_out}, '0);
        check("R1 dir reset", {24'b0, gpio_dir}, '0);

        // directed corners
        access(1'b0, 2'b00, 2'b10, 1'b1, 32'hFFFF_FFA5, 8'h3C); // R2 out write, upper bits ignored
        access(1'b0, 2'b01, 2'b10, 1'b1, 32'h0000_00C3, 8'h81); // R2 dir write
        access(1'b0, 2'b01, 2'b10, 1'b0, 32'h0, 8'h00);         // R3 read dir
        access(1'b0, 2'b10, 2'b10, 1'b0, 32'h0, 8'h5A);         // R4 pin read
        access(1'b0, 2'b10, 2'b10, 1'b0, 32'h0, 8'h00);         // R4 sees 5A
        access(1'b0, 2'b00, 2'b00, 1'b1, 32'h11, 8'h00);        // R6/R8 byte write blocked
        access(1'b0, 2'b01, 2'b01, 1'b1, 32'h22, 8'h00);        // R6/R8 half write blocked
        access(1'b0, 2'b01, 2'b11, 1'b1, 32'h33, 8'h00);        // R6/R8 bad size
        access(1'b0, 2'b01, 2'b00, 1'b0, 32'h0, 8'h00);         // R9 byte read still drives
        access(1'b0, 2'b00, 2'b10, 1'b0, 32'h0, 8'h00);         // R7 read write-only
        access(1'b0, 2'b11, 2'b10, 1'b0, 32'h0, 8'h00);         // R7 read unused
        access(1'b0, 2'b10, 2'b10, 1'b1, 32'h44, 8'h00);        // R7 write read-only
        access(1'b0, 2'b11, 2'b10, 1'b1, 32'h55, 8'h00);        // R7 write unused
        access(1'b1, 2'b00, 2'b10, 1'b1, 32'h66, 8'h00);        // R10 no select

        for (int i = 0; i < 400; i++) begin
            access(($urandom % 5) == 0, 2'($urandom), ($urandom % 3 == 0) ? 2'($urandom) : 2'b10,
                   1'($urandom), $urandom, 8'($urandom));
        end

        @(posedge clk);
        #1 rst = 1'b1;
        @(negedge clk);
        #1;
        m_out = '0; m_dir = '0;
        check("R1 out rerun", {24'b0, gpio_out}, '0);
        check("R1 dir rerun", {24'b0, gpio_dir}, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule